// File: doc/BRIEF.md
# Self-Timed Parallel EEPROM Byte Store

A 512 x 8 non-volatile store that a host reaches through an asynchronous-SRAM style
parallel bus. Reads return the addressed byte while chip enable and output enable are
both low. A write is started by a qualified write-enable strobe. At that point the block
captures the address and data, so the host may change the bus straight away. It then
stays busy for a fixed, self-timed interval. The first half of that interval erases the
target byte to all ones. The second half programs the captured value into it.

The host finds out when the write is finished by polling. During the busy interval every
enabled read returns the inverted top bit of the captured data, with all other bits zero.
Once the interval ends, the stored byte is returned. A glitch filter on the write strobe
and a supply-low input protect the contents. A separate erase input wipes the whole
array, using the same self-timed interval.

The interval length is a parameter with two settings, 200 us and 1 ms. It is expressed in
clock cycles through a cycles-per-microsecond parameter.

Top module: `pee_core`

## Requirements
- R1: While `rst` is high and after its release, every byte reads 8'hFF, and the block is idle (no write in progress).
- R2: `dout_en` equals `!ce_n && !oe_n`. When `dout_en` is low, `dout` is 8'h00. When the block is idle and `dout_en` is high, `dout` is the stored byte at `addr`, with no clock delay.
- R3: A write strobe means `ce_n`=0, `we_n`=0 and `oe_n`=1 together. When the strobe has been present for `FILT_CYC` consecutive rising edges, `addr` and `din` are captured at the `FILT_CYC`-th edge. Bus values after that edge do not affect the write.
- R4: After the capture edge t0, the block is busy for 2*H cycles, where H = (200 or 1000)*`CYC_PER_US`/2. The first H cycles erase the byte to 8'hFF and the next H cycles program it. A read of the written address returns the new byte from the clock edge t0+2*H on.
- R5: While the block is busy, every enabled read of any address returns {~D[7], 7'b0}, where D is the captured data.
- R6: A strobe shorter than `FILT_CYC` edges starts nothing. A strobe held longer starts exactly one write.
- R7: While the block is busy, write strobes and `erase_all` are ignored. The captured address and data stay unchanged.
- R8: If `supply_low` is high at the edge that would start a write or erase, no write or erase starts, and the block stays idle.
- R9: `erase_all` high for one rising edge while idle (and `supply_low` low) starts a busy interval of the same 2*H length. During it, polling returns 8'h00. At its end every byte reads 8'hFF.
- R10: With `LONG_WRITE`=1 the busy interval is 1000*`CYC_PER_US` cycles. With `LONG_WRITE`=0 it is 200*`CYC_PER_US` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| supply_low | input | 1 | Low-supply detect, blocks write and erase starts |
| erase_all | input | 1 | Whole-array erase request |
| addr | input | 9 | Byte address |
| din | input | 8 | Write data from host |
| dout | output | 8 | Read data or poll status |
| dout_en | output | 1 | High when the data bus should be driven |

## Verification
A stuck or mis-timed phase counter shows up on the first write as a completion time other than exactly 2*H edges. The bench measures this to the cycle through polling, for both interval settings. A latch that is overwritten while busy shows as a wrong poll bit within one read and as a wrong stored byte once the interval ends. A filter that is off by one, or a supply-low check that is missing, leaves a byte altered that should read 8'hFF. This can be seen on the first read after the interval.

// File: rtl/pee_pkg.sv
package pee_pkg;

    localparam int unsigned ADDR_W = 9;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned DEPTH  = 1 << ADDR_W;

    localparam int unsigned SHORT_US = 200;
    localparam int unsigned LONG_US  = 1000;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CLEAR = 2'd1,
        ST_PROG  = 2'd2
    } pee_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              whole;   // job wipes the full array
    } pee_job_t;

    // Length of one phase (half of the total busy interval) in clocks.
    function automatic int unsigned half_cycles(input bit long_w,
                                                input int unsigned cyc_per_us);
        int unsigned us;
        us = long_w ? LONG_US : SHORT_US;
        return (us * cyc_per_us) / 2;
    endfunction

    // Status word seen by the host while a job is running.
    function automatic logic [DATA_W-1:0] poll_word(input logic [DATA_W-1:0] d);
        return {~d[DATA_W-1], {(DATA_W-1){1'b0}}};
    endfunction

endpackage

// File: rtl/pee_strobe_filt.sv
module pee_strobe_filt #(
    parameter int unsigned FILT_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe,
    output logic fire
);
    localparam int unsigned CNT_W = $clog2(FILT_CYC + 1);

    logic [CNT_W-1:0] run_q;

    // Count consecutive strobe cycles, saturating so a long pulse fires once.
    always_ff @(posedge clk) begin
        if (rst || !strobe) begin
            run_q <= '0;
        end else if (run_q != CNT_W'(FILT_CYC)) begin
            run_q <= run_q + 1'b1;
        end
    end

    assign fire = strobe && (run_q == CNT_W'(FILT_CYC - 1));

    AST_FIRE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        fire |=> !fire);   // R6

endmodule

// File: rtl/pee_seq.sv
module pee_seq
    import pee_pkg::*;
#(
    parameter int unsigned HALF = 12500
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_fire,
    input  logic              erase_req,
    input  logic              inhibit,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    output logic              busy,
    output pee_job_t          job,
    output logic              clr_byte,
    output logic              clr_all,
    output logic              prog_byte
);
    localparam int unsigned CNT_W = $clog2(HALF + 1);

    pee_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    pee_job_t         job_q;
    logic             start;
    logic             phase_end;

    assign start     = (state_q == ST_IDLE) && !inhibit && (erase_req || wr_fire);
    assign phase_end = (cnt_q == CNT_W'(HALF - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            job_q   <= '{addr: '0, data: '1, whole: 1'b0};
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    cnt_q <= '0;
                    if (start) begin
                        state_q <= ST_CLEAR;
                        // erase request wins over a simultaneous write
                        if (erase_req) job_q <= '{addr: '0, data: '1, whole: 1'b1};
                        else           job_q <= '{addr: addr_in, data: data_in, whole: 1'b0};
                    end
                end
                ST_CLEAR: begin
                    if (phase_end) begin
                        state_q <= ST_PROG;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_PROG: begin
                    if (phase_end) begin
                        state_q <= ST_IDLE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                    cnt_q   <= '0;
                end
            endcase
        end
    end

    assign busy      = (state_q != ST_IDLE);
    assign job       = job_q;
    assign clr_byte  = (state_q == ST_CLEAR) && phase_end && !job_q.whole;
    assign clr_all   = (state_q == ST_CLEAR) && phase_end &&  job_q.whole;
    assign prog_byte = (state_q == ST_PROG)  && phase_end && !job_q.whole;

    AST_INHIBIT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && inhibit) |=> (state_q == ST_IDLE));   // R8

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE) |=> (state_q == ST_IDLE) || $stable(job_q));   // R7

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt_q < CNT_W'(HALF));   // R4

    AST_PROG_AFTER_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PROG && $past(state_q) != ST_PROG) |-> ($past(state_q) == ST_CLEAR));   // R4

endmodule

// File: rtl/pee_array.sv
module pee_array
    import pee_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clr_byte,
    input  logic              clr_all,
    input  logic              prog_byte,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] cells [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_row
        logic hit;
        assign hit = (wr_addr == ADDR_W'(i));

        always_ff @(posedge clk) begin
            if (rst || clr_all) begin
                cells[i] <= '1;
            end else if (clr_byte && hit) begin
                cells[i] <= '1;
            end else if (prog_byte && hit) begin
                cells[i] <= wr_data;
            end
        end
    end

    assign rd_data = cells[rd_addr];

endmodule

// File: rtl/pee_core.sv
module pee_core
    import pee_pkg::*;
#(
    parameter bit          LONG_WRITE = 1'b0,
    parameter int unsigned CYC_PER_US = 125,
    parameter int unsigned FILT_CYC   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              supply_low,
    input  logic              erase_all,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);
    localparam int unsigned HALF = half_cycles(LONG_WRITE, CYC_PER_US);

    logic              strobe;
    logic              wr_fire;
    logic              busy;
    pee_job_t          job;
    logic              clr_byte;
    logic              clr_all;
    logic              prog_byte;
    logic [DATA_W-1:0] cell_q;

    assign strobe = !ce_n && !we_n && oe_n;

    pee_strobe_filt #(.FILT_CYC(FILT_CYC)) i_filt (
        .clk    (clk),
        .rst    (rst),
        .strobe (strobe),
        .fire   (wr_fire)
    );

    pee_seq #(.HALF(HALF)) i_seq (
        .clk       (clk),
        .rst       (rst),
        .wr_fire   (wr_fire),
        .erase_req (erase_all),
        .inhibit   (supply_low),
        .addr_in   (addr),
        .data_in   (din),
        .busy      (busy),
        .job       (job),
        .clr_byte  (clr_byte),
        .clr_all   (clr_all),
        .prog_byte (prog_byte)
    );

    pee_array i_array (
        .clk       (clk),
        .rst       (rst),
        .rd_addr   (addr),
        .wr_addr   (job.addr),
        .wr_data   (job.data),
        .clr_byte  (clr_byte),
        .clr_all   (clr_all),
        .prog_byte (prog_byte),
        .rd_data   (cell_q)
    );

    assign dout_en = !ce_n && !oe_n;

    always_comb begin
        if (!dout_en)  dout = '0;
        else if (busy) dout = poll_word(job.data);
        else           dout = cell_q;
    end

    AST_ONE_WRITE_OP: assert property (@(posedge clk) disable iff (rst)
        !(clr_byte && prog_byte) && !(clr_all && prog_byte));   // R4

endmodule

// File: tb/test_pee_core.sv
module test_pee_core;

    localparam int unsigned FILT = 4;
    localparam int unsigned CPU  = 1;
    localparam int unsigned HS   = 100;   // 200*CPU/2
    localparam int unsigned HL   = 500;   // 1000*CPU/2

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic       supply_low = 1'b0, erase_all = 1'b0;
    logic [8:0] addr = '0;
    logic [7:0] din = '0;
    logic [7:0] dout_s, dout_l;
    logic       den_s, den_l;

    int total = 0;
    int bad   = 0;
    logic [7:0] model_mem [512];

    always #4 clk = ~clk;   // 125 MHz

    pee_core #(.LONG_WRITE(1'b0), .CYC_PER_US(CPU), .FILT_CYC(FILT)) i_pee_core (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .supply_low(supply_low), .erase_all(erase_all), .addr(addr), .din(din),
        .dout(dout_s), .dout_en(den_s));

    pee_core #(.LONG_WRITE(1'b1), .CYC_PER_US(CPU), .FILT_CYC(FILT)) i_pee_core_long (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .supply_low(supply_low), .erase_all(erase_all), .addr(addr), .din(din),
        .dout(dout_l), .dout_en(den_l));

    function automatic logic [7:0] poll_of(input logic [7:0] d);
        return {~d[7], 7'b0};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [8:0] a, output logic [7:0] v);
        @(negedge clk);
        we_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0; addr = a;
        #1;
        v = dout_s;
    endtask

    task automatic wr(input logic [8:0] a, input logic [7:0] d, input int len);
        @(negedge clk);
        oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0; addr = a; din = d;
        for (int i = 0; i < len; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (i == FILT - 1) begin addr = ~a; din = ~d; end
        end
        we_n = 1'b1; ce_n = 1'b1;
    endtask

    task automatic wait_done();
        repeat (2 * HS + 2) @(posedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int ks, kl;
        void'($urandom(32'h5EED1234));
        for (int i = 0; i < 512; i++) model_mem[i] = 8'hFF;

        repeat (5) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1 reset contents; R2 bus disable
        rd(9'h000, v); check("R1 reset byte 0", v, 8'hFF);
        rd(9'h1FF, v); check("R1 reset byte 511", v, 8'hFF);
        rd(9'h0A5, v); check("R1 reset byte 165", v, 8'hFF);
        @(negedge clk); ce_n = 1'b1; #1;
        check("R2 dout_en off", den_s, 1'b0);
        check("R2 dout zero", dout_s, 8'h00);
        oe_n = 1'b1; ce_n = 1'b0; #1;
        check("R2 dout_en needs oe", den_s, 1'b0);

        // R4/R5/R10 exact interval, both settings
        wr(9'h012, 8'h5A, FILT);
        model_mem[9'h012] = 8'h5A;
        ce_n = 1'b0; oe_n = 1'b0; addr = 9'h012; #1;
        check("R5 poll short", dout_s, poll_of(8'h5A));
        check("R5 poll long", dout_l, poll_of(8'h5A));
        ks = -1; kl = -1;
        for (int k = 0; k < 3000; k++) begin
            if (k == 1) addr = 9'h013;
            else if (k == 2) addr = 9'h012;
            #1;
            if (k == 1) check("R5 poll other address", dout_s, poll_of(8'h5A));
            if (ks < 0 && dout_s == 8'h5A) ks = k;
            if (kl < 0 && dout_l == 8'h5A) kl = k;
            if (ks >= 0 && kl >= 0) break;
            @(negedge clk);
        end
        check("R4 busy length short", ks, 2 * HS);
        check("R10 busy length long", kl, 2 * HL);

        // R3 capture at filter edge, later bus change ignored; R6 long pulse one write
        wr(9'h040, 8'hC3, 7);
        model_mem[9'h040] = 8'hC3;
        wait_done();
        rd(9'h040, v); check("R3 captured data", v, 8'hC3);
        rd(9'h1BF, v); check("R3 later bus value unused", v, 8'hFF);
        rd(9'h1BF, v); #1; check("R6 no second write", v, 8'hFF);

        // R6 short pulse
        wr(9'h041, 8'h00, FILT - 1);
        repeat (3) @(posedge clk);
        rd(9'h041, v); check("R6 short pulse ignored", v, 8'hFF);

        // R8 supply low
        @(negedge clk); supply_low = 1'b1;
        wr(9'h042, 8'h11, FILT);
        @(negedge clk); supply_low = 1'b0;
        rd(9'h042, v); check("R8 inhibited write", v, 8'hFF);

        // R7 strobes and erase during busy ignored
        wr(9'h043, 8'h77, FILT);
        model_mem[9'h043] = 8'h77;
        wr(9'h044, 8'h99, FILT);
        @(negedge clk); erase_all = 1'b1;
        @(negedge clk); erase_all = 1'b0;
        rd(9'h044, v); check("R7 poll keeps first data", v, poll_of(8'h77));
        wait_done();
        rd(9'h043, v); check("R7 first write kept", v, 8'h77);
        rd(9'h044, v); check("R7 busy write dropped", v, 8'hFF);
        rd(9'h040, v); check("R7 busy erase dropped", v, 8'hC3);

        // random writes: R3 R6 R8
        for (int n = 0; n < 24; n++) begin
            logic [8:0] a;
            logic [7:0] d;
            int len;
            bit low;
            a = 9'($urandom % 512);
            d = 8'($urandom);
            len = 1 + int'($urandom % 6);
            low = (($urandom % 5) == 0);
            @(negedge clk); supply_low = low;
            wr(a, d, len);
            @(negedge clk); supply_low = 1'b0;
            if (len >= FILT && !low) model_mem[a] = d;
            wait_done();
            rd(a, v); check("R3 random write", v, model_mem[a]);
            for (int j = 0; j < 2; j++) begin
                logic [8:0] b;
                b = 9'($urandom % 512);
                rd(b, v); check("R2 random read", v, model_mem[b]);
            end
        end

        // R9 whole erase
        @(negedge clk); erase_all = 1'b1; ce_n = 1'b1;
        @(negedge clk); erase_all = 1'b0;
        rd(9'h012, v); check("R9 erase poll", v, 8'h00);
        wait_done();
        rd(9'h012, v); check("R9 erased 0x012", v, 8'hFF);
        rd(9'h040, v); check("R9 erased 0x040", v, 8'hFF);
        rd(9'h043, v); check("R9 erased 0x043", v, 8'hFF);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule